// File: doc/BRIEF.md
# Frame-Size-Scaled Dual SPI FIFO

This block holds the transmit and receive word queues of an SPI master. Each direction owns 32 words of 32-bit storage, but only part of it may be usable: the usable depth follows the configured frame width when the large-queue mode is on (more entries for narrow frames and fewer for wide ones) and is fixed at four entries when that mode is off. The depth is captured from the frame size and mode inputs only when the control register write strobe `cfg_wr_i` is pulsed.

The register interface pushes transmit words and pops received words. The serial engine pops transmit words and pushes received words. Each queue reports empty, full and full-next status, computed from its occupancy and the captured depth. The receive queue also keeps a sticky overflow flag. Each queue has its own synchronous clear. The head word is presented on the data output at all times, and the output reads zero while the queue is empty.

Top module: `spi_dual_fifo`

## Requirements
- R1: With large mode on (`big_fifo_i`=1) at the last `cfg_wr_i`, a frame size of 0..8 gives a usable depth of 32, 9..16 gives 16, and 17..31 gives 8.
- R2: With large mode off at the last `cfg_wr_i`, and after reset, the usable depth is 4 whatever the frame size.
- R3: Changes of `frame_size_i` or `big_fifo_i` without a `cfg_wr_i` pulse leave the usable depth unchanged.
- R4: `*_empty_o` is 1 at occupancy 0. `*_full_next_o` is 1 at occupancy depth-1. `*_full_o` is 1 at occupancy greater than or equal to depth. All flags follow the clock edge that changes the occupancy.
- R5: A transmit push while `tx_full_o` is 1 is discarded and changes neither the contents nor the flags.
- R6: A receive push while `rx_full_o` is 1 drops the word and sets `rx_ovf_o`, which stays set until it is cleared.
- R7: A receive pop clears `rx_ovf_o` and removes one entry, so `rx_full_o` drops and `rx_empty_o` rises when the last entry leaves.
- R8: A clear input empties its queue in one cycle: the empty flag is 1, the full and full-next flags are 0, and for the receive queue `rx_ovf_o` is 0. A clear takes priority over a push or pop in the same cycle.
- R9: While a queue is empty its data output reads zero, and a pop on an empty queue changes nothing.
- R10: Words leave each queue in push order, and the data output shows the oldest entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Control write strobe that captures the depth configuration |
| frame_size_i | input | 5 | Configured frame width in bits |
| big_fifo_i | input | 1 | Large-queue mode enable |
| tx_clr_i | input | 1 | Synchronous clear of the transmit queue |
| tx_push_i | input | 1 | Transmit push strobe |
| tx_data_i | input | 32 | Transmit push data |
| tx_pop_i | input | 1 | Transmit pop strobe |
| tx_data_o | output | 32 | Transmit head word, zero when empty |
| tx_full_o | output | 1 | Transmit queue full |
| tx_full_next_o | output | 1 | Transmit queue one entry short of full |
| tx_empty_o | output | 1 | Transmit queue empty |
| rx_clr_i | input | 1 | Synchronous clear of the receive queue |
| rx_push_i | input | 1 | Receive push strobe |
| rx_data_i | input | 32 | Receive push data |
| rx_pop_i | input | 1 | Receive pop strobe |
| rx_data_o | output | 32 | Receive head word, zero when empty |
| rx_full_o | output | 1 | Receive queue full |
| rx_full_next_o | output | 1 | Receive queue one entry short of full |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |

## Verification
The assertions check several properties on every cycle: the mutual exclusion of the three occupancy flags, the zero output of an empty queue, the stable head and full flag after a refused transmit push, the setting and clearing of the receive overflow, and the state after a clear. The depth mapping for each frame-size band, the point at which a configuration is captured, exact occupancy counts at each boundary, and push-order data can only be shown by the bench. It fills the queues to each depth and compares every output against a queue model on every cycle.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  // Usable depth from frame width and mode; tiers are max, max/2, max/4.
  function automatic int unsigned usable_depth(input int unsigned fsz,
                                               input logic        big,
                                               input int unsigned max_d,
                                               input int unsigned small_d,
                                               input int unsigned narrow_bits,
                                               input int unsigned mid_bits);
    if (!big) return small_d;
    if (fsz <= narrow_bits) return max_d;
    if (fsz <= mid_bits) return max_d / 2;
    return max_d / 4;
  endfunction
endpackage

// File: rtl/spi_depth_sel.sv
module spi_depth_sel
  import spi_fifo_pkg::*;
#(
  parameter int unsigned MAX_DEPTH   = 32,
  parameter int unsigned SMALL_DEPTH = 4,
  parameter int unsigned NARROW_BITS = 8,
  parameter int unsigned MID_BITS    = 16,
  parameter int unsigned FSZ_W       = 5,
  parameter int unsigned CW          = $clog2(MAX_DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [FSZ_W-1:0] frame_size_i,
  input  logic             big_fifo_i,
  output logic [CW-1:0]    depth_o
);
  logic [CW-1:0] depth_q;

  // Captured only on a control write.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= CW'(SMALL_DEPTH);
    end else if (cfg_wr_i) begin
      depth_q <= CW'(usable_depth(int'(frame_size_i), big_fifo_i, MAX_DEPTH,
                                  SMALL_DEPTH, NARROW_BITS, MID_BITS));
    end
  end

  assign depth_o = depth_q;
endmodule

// File: rtl/spi_fifo_core.sv
module spi_fifo_core #(
  parameter int unsigned MAX_DEPTH = 32,  // power of two
  parameter int unsigned DW        = 32,
  parameter bit          HAS_OVF   = 1'b0,
  localparam int unsigned AW       = $clog2(MAX_DEPTH),
  localparam int unsigned CW       = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  input  logic [CW-1:0] depth_i,
  output logic [DW-1:0] data_o,
  output logic          full_o,
  output logic          full_next_o,
  output logic          empty_o,
  output logic          ovf_o
);
  logic [DW-1:0] mem [MAX_DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o     = (cnt_q == '0);
  assign full_o      = (cnt_q >= depth_i);
  assign full_next_o = (cnt_q == depth_i - CW'(1));
  assign push_ok     = push_i && !full_o;
  assign pop_ok      = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= wr_q + AW'(1);
      if (pop_ok)  rd_q <= rd_q + AW'(1);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wr_q] <= data_i;
  end

  assign data_o = empty_o ? '0 : mem[rd_q];

  generate
    if (HAS_OVF) begin : g_ovf
      logic ovf_q;
      // A refused push wins over a pop in the same cycle.
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                ovf_q <= 1'b0;
        else if (clr_i)             ovf_q <= 1'b0;
        else if (push_i && full_o)  ovf_q <= 1'b1;
        else if (pop_i)             ovf_q <= 1'b0;
      end
      assign ovf_o = ovf_q;
    end else begin : g_no_ovf
      assign ovf_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/spi_dual_fifo.sv
module spi_dual_fifo #(
  parameter int unsigned MAX_DEPTH   = 32,
  parameter int unsigned SMALL_DEPTH = 4,
  parameter int unsigned NARROW_BITS = 8,
  parameter int unsigned MID_BITS    = 16,
  parameter int unsigned FSZ_W       = 5,
  parameter int unsigned DW          = 32,
  localparam int unsigned CW         = $clog2(MAX_DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic [FSZ_W-1:0] frame_size_i,
  input  logic             big_fifo_i,
  input  logic             tx_clr_i,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_data_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_data_o,
  output logic             tx_full_o,
  output logic             tx_full_next_o,
  output logic             tx_empty_o,
  input  logic             rx_clr_i,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_data_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_data_o,
  output logic             rx_full_o,
  output logic             rx_full_next_o,
  output logic             rx_empty_o,
  output logic             rx_ovf_o
);
  logic [CW-1:0] depth;
  logic          tx_ovf_nc;

  spi_depth_sel #(
    .MAX_DEPTH(MAX_DEPTH), .SMALL_DEPTH(SMALL_DEPTH), .NARROW_BITS(NARROW_BITS),
    .MID_BITS(MID_BITS), .FSZ_W(FSZ_W), .CW(CW)
  ) u_depth (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i),
    .frame_size_i(frame_size_i), .big_fifo_i(big_fifo_i), .depth_o(depth)
  );

  spi_fifo_core #(.MAX_DEPTH(MAX_DEPTH), .DW(DW), .HAS_OVF(1'b0)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tx_clr_i),
    .push_i(tx_push_i), .data_i(tx_data_i), .pop_i(tx_pop_i), .depth_i(depth),
    .data_o(tx_data_o), .full_o(tx_full_o), .full_next_o(tx_full_next_o),
    .empty_o(tx_empty_o), .ovf_o(tx_ovf_nc)
  );

  spi_fifo_core #(.MAX_DEPTH(MAX_DEPTH), .DW(DW), .HAS_OVF(1'b1)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(rx_clr_i),
    .push_i(rx_push_i), .data_i(rx_data_i), .pop_i(rx_pop_i), .depth_i(depth),
    .data_o(rx_data_o), .full_o(rx_full_o), .full_next_o(rx_full_next_o),
    .empty_o(rx_empty_o), .ovf_o(rx_ovf_o)
  );
endmodule

// File: rtl/spi_dual_fifo_chk.sv
module spi_dual_fifo_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_wr_i,
  input logic          tx_clr_i,
  input logic          tx_push_i,
  input logic          tx_pop_i,
  input logic [DW-1:0] tx_data_o,
  input logic          tx_full_o,
  input logic          tx_full_next_o,
  input logic          tx_empty_o,
  input logic          rx_clr_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic [DW-1:0] rx_data_o,
  input logic          rx_full_o,
  input logic          rx_full_next_o,
  input logic          rx_empty_o,
  input logic          rx_ovf_o
);
  a_r4_tx_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_full_o, tx_full_next_o, tx_empty_o}));

  a_r4_rx_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_full_o, rx_full_next_o, rx_empty_o}));

  a_r5_tx_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && tx_push_i && !tx_pop_i && !tx_clr_i && !cfg_wr_i)
    |=> (tx_full_o && $stable(tx_data_o)));

  a_r6_rx_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_o && rx_push_i && !rx_clr_i) |=> rx_ovf_o);

  a_r7_pop_clears_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && !rx_push_i && !rx_clr_i) |=> !rx_ovf_o);

  a_r8_tx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_clr_i |=> (tx_empty_o && !tx_full_o && !tx_full_next_o));

  a_r8_rx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr_i |=> (rx_empty_o && !rx_full_o && !rx_ovf_o));

  a_r9_tx_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> (tx_data_o == '0));

  a_r9_rx_empty_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> (rx_data_o == '0));

  a_r4_push_leaves_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_empty_o && tx_push_i && !tx_clr_i) |=> !tx_empty_o);
endmodule

bind spi_dual_fifo spi_dual_fifo_chk #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i),
  .tx_clr_i(tx_clr_i), .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i),
  .tx_data_o(tx_data_o), .tx_full_o(tx_full_o), .tx_full_next_o(tx_full_next_o),
  .tx_empty_o(tx_empty_o), .rx_clr_i(rx_clr_i), .rx_push_i(rx_push_i),
  .rx_pop_i(rx_pop_i), .rx_data_o(rx_data_o), .rx_full_o(rx_full_o),
  .rx_full_next_o(rx_full_next_o), .rx_empty_o(rx_empty_o), .rx_ovf_o(rx_ovf_o)
);

// File: tb/spi_dual_fifo_bench.sv
`timescale 1ns/1ps
module spi_dual_fifo_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [4:0]  frame_size_i = '0;
  logic        big_fifo_i = 1'b0;
  logic        tx_clr_i = 1'b0, tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [31:0] tx_data_i = '0;
  logic        rx_clr_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [31:0] rx_data_i = '0;
  logic [31:0] tx_data_o, rx_data_o;
  logic        tx_full_o, tx_full_next_o, tx_empty_o;
  logic        rx_full_o, rx_full_next_o, rx_empty_o, rx_ovf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] txq[$];
  logic [31:0] rxq[$];
  int          dep_m = 4;
  bit          ovf_m = 1'b0;

  always #2.5 clk_i = ~clk_i;

  spi_dual_fifo u_spi_dual_fifo (.*);

  function automatic int dep_of(input logic [4:0] fs, input logic big);
    if (!big) return 4;
    if (fs <= 5'd8) return 32;
    if (fs <= 5'd16) return 16;
    return 8;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "tx_data", tx_data_o, txq.size() ? txq[0] : 32'd0);
    chk(tag, "tx_empty", 32'(tx_empty_o), 32'(txq.size() == 0));
    chk(tag, "tx_full", 32'(tx_full_o), 32'(txq.size() >= dep_m));
    chk(tag, "tx_full_next", 32'(tx_full_next_o), 32'(txq.size() == dep_m - 1));
    chk(tag, "rx_data", rx_data_o, rxq.size() ? rxq[0] : 32'd0);
    chk(tag, "rx_empty", 32'(rx_empty_o), 32'(rxq.size() == 0));
    chk(tag, "rx_full", 32'(rx_full_o), 32'(rxq.size() >= dep_m));
    chk(tag, "rx_full_next", 32'(rx_full_next_o), 32'(rxq.size() == dep_m - 1));
    chk(tag, "rx_ovf", 32'(rx_ovf_o), 32'(ovf_m));
  endtask

  task automatic model_edge();
    int  old_dep;
    bit  rx_was_full;
    old_dep = dep_m;
    if (tx_clr_i) txq.delete();
    else begin
      bit acc;
      acc = tx_push_i && (txq.size() < old_dep);
      if (tx_pop_i && txq.size() > 0) void'(txq.pop_front());
      if (acc) txq.push_back(tx_data_i);
    end
    rx_was_full = (rxq.size() >= old_dep);
    if (rx_clr_i) begin
      rxq.delete();
      ovf_m = 1'b0;
    end else begin
      if (rx_push_i && rx_was_full) ovf_m = 1'b1;
      else if (rx_pop_i) ovf_m = 1'b0;
      if (rx_pop_i && rxq.size() > 0) void'(rxq.pop_front());
      if (rx_push_i && !rx_was_full) rxq.push_back(rx_data_i);
    end
    if (cfg_wr_i) dep_m = dep_of(frame_size_i, big_fifo_i);
  endtask

  task automatic idle();
    cfg_wr_i = 1'b0; tx_clr_i = 1'b0; tx_push_i = 1'b0; tx_pop_i = 1'b0;
    rx_clr_i = 1'b0; rx_push_i = 1'b0; rx_pop_i = 1'b0;
  endtask

  task automatic tick(input string tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare_all(tag);
    idle();
  endtask

  task automatic cfg(input logic [4:0] fs, input logic big, input string tag);
    frame_size_i = fs; big_fifo_i = big; cfg_wr_i = 1'b1;
    tick(tag);
  endtask

  task automatic fill_tx(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      tx_push_i = 1'b1; tx_data_i = 32'hA000_0000 + 32'(i);
      tick(tag);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog all actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all("R2");                      // reset state, depth 4

    // R2/R5: small mode holds 4; a fifth push is discarded
    fill_tx(4, "R2");
    fill_tx(1, "R5");
    chk("R5", "tx_head_after_drop", tx_data_o, 32'hA000_0000);
    // R10 order, R9 pop on empty
    for (int i = 0; i < 4; i++) begin tx_pop_i = 1'b1; tick("R10"); end
    tx_pop_i = 1'b1; tick("R9");
    rx_pop_i = 1'b1; tick("R9");

    // R1: depth bands in large mode
    cfg(5'd8, 1'b1, "R1");  fill_tx(33, "R1"); tx_clr_i = 1'b1; tick("R8");
    cfg(5'd16, 1'b1, "R1"); fill_tx(17, "R1"); tx_clr_i = 1'b1; tick("R8");
    cfg(5'd20, 1'b1, "R1"); fill_tx(9, "R1");  tx_clr_i = 1'b1; tick("R8");
    cfg(5'd31, 1'b1, "R1"); fill_tx(9, "R1");  tx_clr_i = 1'b1; tick("R8");
    cfg(5'd9, 1'b1, "R1");
    // R3: no strobe, depth must stay 16
    frame_size_i = 5'd0; big_fifo_i = 1'b0;
    fill_tx(17, "R3");
    chk("R3", "tx_full_at_16", 32'(tx_full_o), 32'd1);
    tx_clr_i = 1'b1; tx_push_i = 1'b1; tick("R8");   // clear beats push

    // R6/R7: receive overflow in small mode
    cfg(5'd8, 1'b0, "R2");
    for (int i = 0; i < 6; i++) begin
      rx_push_i = 1'b1; rx_data_i = 32'h5500_0000 + 32'(i);
      tick(i < 4 ? "R4" : "R6");
    end
    chk("R6", "rx_ovf_sticky", 32'(rx_ovf_o), 32'd1);
    rx_pop_i = 1'b1; tick("R7");
    chk("R7", "rx_ovf_cleared", 32'(rx_ovf_o), 32'd0);
    for (int i = 0; i < 3; i++) begin rx_pop_i = 1'b1; tick("R7"); end
    rx_push_i = 1'b1; rx_data_i = 32'h77; tick("R10");
    rx_clr_i = 1'b1; tick("R8");

    // random mix
    cfg(5'd12, 1'b1, "R1");
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      cfg_wr_i = (r < 2);
      if (cfg_wr_i) begin
        frame_size_i = 5'($urandom_range(0, 31));
        big_fifo_i = 1'($urandom_range(0, 1));
      end
      tx_clr_i  = ($urandom_range(0, 199) == 0);
      rx_clr_i  = ($urandom_range(0, 199) == 0);
      tx_push_i = ($urandom_range(0, 99) < 60);
      tx_pop_i  = ($urandom_range(0, 99) < 40);
      rx_push_i = ($urandom_range(0, 99) < 60);
      rx_pop_i  = ($urandom_range(0, 99) < 40);
      tx_data_i = $urandom();
      rx_data_i = $urandom();
      tick("R4/R6/R10");
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule